// File: doc/BRIEF.md
# Serial Two-Register Control Port

This block is a synchronous serial slave that receives control frames over three wires: a serial clock, a serial data line and a frame enable. Each frame is eleven bits long. The first bit is a target-select bit, and the other ten bits are a payload sent most significant bit first. When the frame closes, the payload goes into one of two 10-bit registers. The mode register drives a set of enable and select pins for motor and actuator drivers. The data register holds a current-gain range bit and a 9-bit offset-binary converter code.

The serial wires are asynchronous to the system clock `clk`. They pass through a synchronizer, and the block detects serial clock edges in the system domain. A frame with too few bits is thrown away. A frame with too many bits keeps only its final eleven bits. A one-cycle strobe marks each register write. The data register strobe `dac_upd` also acts as the valid for the converter code.

The converter code leaves the block as a valid-only stream, and there is no back-pressure. `dac_upd` is high for exactly one cycle, the cycle in which `gain_hi` and `dac_code` first show the new value. A downstream consumer must take the value in that cycle or read the held outputs later.

Top module: `ser_ctrl_port`

## Requirements
- R1: When `rst_n` is low, every register output and both strobes are 0. Every driver enable therefore comes up off.
- R2: A frame has eleven bits, each sampled on a rising edge of `ser_clk` while `ser_en` is high. The target-select bit comes first, then payload bits 9 down to 0. If the select bit is 1, the payload is written to the mode register and `mode_word` shows it.
- R3: If the select bit is 0, the payload is written to the data register. `gain_hi` receives payload bit 9 (1 selects the high current range). `dac_code` receives payload bits 8..0, where 0x100 means zero, 0x1FF is full positive and 0x000 is full negative.
- R4: A frame with fewer than eleven sampled bits changes neither register and raises no strobe.
- R5: A frame with more than eleven sampled bits is treated as if it held only its last eleven bits. The select bit is the eleventh bit from the end.
- R6: The mode pins follow the mode register bits as follows: `spin_en` is bit 0, `brake` is bit 1, `half_wave` is bit 3, `ext_comm` is bit 4, `soft_sw` is bit 5, `vcm_en` is bit 6, `retract` is bit 7, `pole12` is bit 8 (0 selects eight poles) and `boost_lowf` is bit 9.
- R7: Mode register bit 2 is unused and always reads 0, whatever value the frame carries.
- R8: A register is written only when `ser_en` falls. Each accepted frame raises exactly one one-cycle strobe: `mode_wr` for the mode register or `dac_upd` for the data register. The strobe rises in the same cycle as the new register value.
- R9: A frame written to one register leaves the other register unchanged.
- R10: `ser_clk` edges while `ser_en` is low have no effect. The bit count restarts at every rising edge of `ser_en`, so two short frames never combine into one valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_dat | input | 1 | Serial data, sampled on rising ser_clk |
| ser_en | input | 1 | Frame enable, high for the length of a frame |
| mode_word | output | 10 | Mode register contents |
| spin_en | output | 1 | Spindle drive enable |
| brake | output | 1 | Brake enable |
| half_wave | output | 1 | Half-wave drive select |
| ext_comm | output | 1 | External commutation select |
| soft_sw | output | 1 | Soft switching select |
| vcm_en | output | 1 | Voice-coil drive enable |
| retract | output | 1 | Head retract request |
| pole12 | output | 1 | Twelve-pole motor select |
| boost_lowf | output | 1 | Booster low-frequency select |
| gain_hi | output | 1 | High current range select |
| dac_code | output | 9 | Offset-binary converter code |
| mode_wr | output | 1 | One-cycle mode register write strobe |
| dac_upd | output | 1 | One-cycle data register write strobe and code valid |

## Verification
Serial bits reach the shift window SYNC_STAGES+1 clk cycles after their `ser_clk` edge. The register outputs and their strobe follow the falling edge of `ser_en` by SYNC_STAGES+2 cycles, which is four cycles with the defaults. The bench drives the serial wires on falling `clk` edges and holds each `ser_clk` level for four cycles. After raising `ser_en` it waits four cycles before the first bit. After dropping `ser_en` it waits twelve cycles before it samples the registers, again on a falling edge. The strobes are counted across that whole window, so a missing, doubled or misdirected strobe is seen regardless of which cycle it lands in.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int PAYLOAD_W = 10;
  localparam int FRAME_W   = PAYLOAD_W + 1;

  // mode register bit positions (decoded by the driver pins)
  localparam int MB_SPIN  = 0;
  localparam int MB_BRAKE = 1;
  localparam int MB_SPARE = 2;
  localparam int MB_HALF  = 3;
  localparam int MB_EXTC  = 4;
  localparam int MB_SOFT  = 5;
  localparam int MB_VCM   = 6;
  localparam int MB_RETR  = 7;
  localparam int MB_POLE  = 8;
  localparam int MB_BOOST = 9;

  localparam logic [PAYLOAD_W-1:0] MODE_KEEP = ~(PAYLOAD_W'(1) << MB_SPARE);

  typedef enum logic {TGT_DATA = 1'b0, TGT_MODE = 1'b1} target_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else if (STAGES == 1) chain <= d_async[b];
      else chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/scp_frame_rx.sv
module scp_frame_rx
  import scp_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_W,
  localparam int PAY_W = FRAME_BITS - 1,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_s,
  input  logic             sdi_s,
  input  logic             sen_s,
  output logic             commit_mode,
  output logic             commit_data,
  output logic [PAY_W-1:0] frame_data
);
  logic                  sck_d, sen_d;
  logic [FRAME_BITS-1:0] win;
  logic [CNT_W-1:0]      cnt;
  logic                  sck_rise, sen_rise, sen_fall, take, full;
  target_e               tgt;

  assign sck_rise = sck_s & ~sck_d;
  assign sen_rise = sen_s & ~sen_d;
  assign sen_fall = ~sen_s & sen_d;
  assign take     = sen_s & sen_d & sck_rise;
  assign full     = (cnt == CNT_W'(FRAME_BITS));
  assign tgt      = target_e'(win[FRAME_BITS-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sen_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      sen_d <= sen_s;
    end
  end

  // sliding window: the oldest bit drops off when a frame runs long
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else if (take) win <= {win[FRAME_BITS-2:0], sdi_s};
  end

  // bit counter saturating at the frame length, restarted per frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (sen_rise) cnt <= '0;
    else if (take && !full) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_mode <= 1'b0;
      commit_data <= 1'b0;
      frame_data  <= '0;
    end else begin
      commit_mode <= sen_fall & full & (tgt == TGT_MODE);
      commit_data <= sen_fall & full & (tgt == TGT_DATA);
      if (sen_fall) frame_data <= win[PAY_W-1:0];
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS)); // R5
  AST_SHORT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_fall && !full) |=> !(commit_mode || commit_data)); // R4
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_mode && commit_data)); // R8
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sen_s && !sen_d) |=> $stable(win)); // R10
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
#(
  parameter int PAY_W = PAYLOAD_W,
  parameter logic [PAY_W-1:0] KEEP = MODE_KEEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_mode,
  input  logic             commit_data,
  input  logic [PAY_W-1:0] frame_data,
  output logic [PAY_W-1:0] mode_q,
  output logic [PAY_W-1:0] data_q,
  output logic             mode_wr,
  output logic             data_wr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      data_q  <= '0;
      mode_wr <= 1'b0;
      data_wr <= 1'b0;
    end else begin
      mode_wr <= commit_mode;
      data_wr <= commit_data;
      if (commit_mode) mode_q <= frame_data & KEEP;
      if (commit_data) data_q <= frame_data;
    end
  end

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_mode |=> $stable(mode_q)); // R9
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_data |=> $stable(data_q)); // R9
  AST_MODE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !mode_wr); // R8
  AST_DATA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !data_wr); // R8
endmodule

// File: rtl/ser_ctrl_port.sv
module ser_ctrl_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 ser_en,
  output logic [PAYLOAD_W-1:0] mode_word,
  output logic                 spin_en,
  output logic                 brake,
  output logic                 half_wave,
  output logic                 ext_comm,
  output logic                 soft_sw,
  output logic                 vcm_en,
  output logic                 retract,
  output logic                 pole12,
  output logic                 boost_lowf,
  output logic                 gain_hi,
  output logic [PAYLOAD_W-2:0] dac_code,
  output logic                 mode_wr,
  output logic                 dac_upd
);
  logic [2:0]           pins_s;
  logic                 c_mode, c_data;
  logic [PAYLOAD_W-1:0] fdata, mode_q, data_q;

  scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ser_en, ser_dat, ser_clk}), .d_sync(pins_s)
  );

  scp_frame_rx #(.FRAME_BITS(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[0]), .sdi_s(pins_s[1]), .sen_s(pins_s[2]),
    .commit_mode(c_mode), .commit_data(c_data), .frame_data(fdata)
  );

  scp_regs #(.PAY_W(PAYLOAD_W), .KEEP(MODE_KEEP)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_mode(c_mode), .commit_data(c_data), .frame_data(fdata),
    .mode_q(mode_q), .data_q(data_q), .mode_wr(mode_wr), .data_wr(dac_upd)
  );

  assign mode_word  = mode_q;
  assign spin_en    = mode_q[MB_SPIN];
  assign brake      = mode_q[MB_BRAKE];
  assign half_wave  = mode_q[MB_HALF];
  assign ext_comm   = mode_q[MB_EXTC];
  assign soft_sw    = mode_q[MB_SOFT];
  assign vcm_en     = mode_q[MB_VCM];
  assign retract    = mode_q[MB_RETR];
  assign pole12     = mode_q[MB_POLE];
  assign boost_lowf = mode_q[MB_BOOST];
  assign gain_hi    = data_q[PAYLOAD_W-1];
  assign dac_code   = data_q[PAYLOAD_W-2:0];

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr && dac_upd)); // R8
endmodule

// File: tb/sim_ser_ctrl_port.sv
module sim_ser_ctrl_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic [9:0] mode_word;
  logic spin_en, brake, half_wave, ext_comm, soft_sw, vcm_en, retract, pole12, boost_lowf;
  logic gain_hi, mode_wr, dac_upd;
  logic [8:0] dac_code;

  int checks = 0, fails = 0;
  int n_mode_wr = 0, n_dac_upd = 0;
  logic [9:0] exp_mode = '0, exp_data = '0;

  always #4 clk = ~clk;

  ser_ctrl_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
    .mode_word(mode_word), .spin_en(spin_en), .brake(brake), .half_wave(half_wave),
    .ext_comm(ext_comm), .soft_sw(soft_sw), .vcm_en(vcm_en), .retract(retract),
    .pole12(pole12), .boost_lowf(boost_lowf), .gain_hi(gain_hi), .dac_code(dac_code),
    .mode_wr(mode_wr), .dac_upd(dac_upd)
  );

  always @(posedge clk) begin
    if (mode_wr) n_mode_wr++;
    if (dac_upd) n_dac_upd++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] pin_word();
    return {boost_lowf, pole12, retract, vcm_en, soft_sw, ext_comm, half_wave, 1'b0, brake, spin_en};
  endfunction

  // send the lowest nbits of bits, most significant first; idle clocks optional
  task automatic send(int nbits, logic [31:0] bits, bit idle_clocks);
    if (idle_clocks) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk) begin ser_dat = ~ser_dat; ser_clk = 1'b1; end
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
      end
    end
    @(negedge clk) ser_en = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ser_en = 1'b0;
  endtask

  // bench model of a frame, then checks after the commit window
  task automatic frame(int nbits, logic [31:0] bits, bit idle_clocks);
    int m0 = n_mode_wr, d0 = n_dac_upd;
    int em = 0, ed = 0;
    logic [10:0] last = bits[10:0];
    send(nbits, bits, idle_clocks);
    if (nbits >= 11) begin
      if (last[10]) begin exp_mode = last[9:0] & 10'h3FB; em = 1; end
      else begin exp_data = last[9:0]; ed = 1; end
    end
    repeat (12) @(negedge clk);
    chk(nbits < 11 ? "R4 mode_wr count" : "R8 mode_wr count", n_mode_wr - m0, em);
    chk(nbits < 11 ? "R4 dac_upd count" : "R8 dac_upd count", n_dac_upd - d0, ed);
    chk(nbits > 11 ? "R5 mode_word" : "R2 R9 mode_word", mode_word, exp_mode);
    chk(nbits > 11 ? "R5 data reg" : "R3 R9 data reg", {gain_hi, dac_code}, exp_data);
    chk("R6 pin map", pin_word(), exp_mode);
    chk("R7 spare bit", mode_word[2], 1'b0);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    chk("R1 mode_word", mode_word, 0);
    chk("R1 data reg", {gain_hi, dac_code}, 0);
    chk("R1 strobes", {mode_wr, dac_upd}, 0);
    chk("R1 pins", pin_word(), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2 mode write, all ones including spare bit (R7)
    frame(11, {21'd0, 1'b1, 10'h3FF}, 0);
    // R3 data write: zero code, high range, then full negative low range
    frame(11, {21'd0, 1'b0, 1'b1, 9'h100}, 0);
    frame(11, {21'd0, 1'b0, 1'b0, 9'h000}, 0);
    frame(11, {21'd0, 1'b0, 1'b1, 9'h1FF}, 0);
    // R6 walking one over mode bits
    for (int b = 0; b < 10; b++) frame(11, {21'd0, 1'b1, 10'(1 << b)}, 0);
    // R4 short frames
    frame(10, 32'h3FF, 0);
    frame(1, 32'h1, 0);
    // R10 two short frames must not merge; idle clocks ignored
    frame(6, 32'h2A, 0);
    frame(5, 32'h15, 0);
    frame(11, {21'd0, 1'b1, 10'h155}, 1);
    // R5 long frames
    frame(14, {18'd0, 3'b010, 1'b1, 10'h2AA}, 0);
    frame(16, {16'd0, 5'b11111, 1'b0, 10'h0F3}, 0);
    // random mix
    for (int n = 0; n < 40; n++) begin
      int len = 8 + ($urandom % 9);
      frame(len, $urandom, ($urandom % 4) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule